// File: doc/BRIEF.md
# Presettable Up/Down Programmable Divider

This block is a synchronous binary counter built from chained 4-bit digits. Each digit can count up, count down, load a parallel preset, or clear. A synchronous carry chain links the digits, and the default build uses two digits for 8 bits. An up step moves a digit only when every lower digit is at all ones. A down step moves a digit only when every lower digit is at all zeros. Because every digit changes on the same edge, the full count never passes through transient values.

Two registered strobes mark a full-width wrap, one for each direction. They last one cycle, so a further counter can use them as a step enable and extend the chain.

In reload mode the down direction becomes a programmable divider. A down step taken at count 1 reloads the preset instead of entering zero. The down strobe therefore pulses once every P down steps, and the ratio is set by the preset value alone. All reloads happen on the clock edge, so the divider output has no glitches.

Top module: `updn_divider`

## Requirements
- R1: While `rst_n` is low, or in the cycle after a clock edge with `clr` high, `count` is 0 and both strobes are 0. `clr` wins over loading and counting.
- R2: With `clr` low and `load_n` low at an edge, `count` takes the value of `preset`. This overrides both enables and reload mode, and both strobes are 0 in the next cycle.
- R3: With only `up_en` high (no clear, no load), `count` increases by one at each edge modulo 2^W. A carry crosses from one 4-bit digit into the next, for example 0x0F becomes 0x10.
- R4: With only `dn_en` high and reload mode off, `count` decreases by one at each edge modulo 2^W. A borrow crosses digits, for example 0x10 becomes 0x0F.
- R5: With both enables high, or both low (no clear, no load), `count` holds.
- R6: `up_tc` is high for exactly the one cycle that follows an up step from all ones to 0. It is low in all other cycles.
- R7: With reload mode off, `dn_tc` is high for exactly the one cycle that follows a down step from 0 to all ones.
- R8: With `reload_en` high, a down step at count 1 loads `preset` and raises `dn_tc` for one cycle. With preset P ≥ 1 the count therefore runs P, P-1, …, 1, P, and `dn_tc` pulses once every P down steps. Changing `preset` changes the ratio.
- R9: With `reload_en` high, a down step at count 0 loads `preset` without raising `dn_tc`. As a result, a preset of 0 holds `count` at 0 and `dn_tc` never pulses.
- R10: `up_tc` and `dn_tc` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| clr | input | 1 | Synchronous master clear, highest priority |
| up_en | input | 1 | Up-count enable |
| dn_en | input | 1 | Down-count enable |
| reload_en | input | 1 | Self-reload divider mode |
| load_n | input | 1 | Active-low synchronous parallel load |
| preset | input | W (8) | Parallel load value and divide ratio |
| count | output | W (8) | Current count |
| up_tc | output | 1 | One-cycle pulse after an up wrap |
| dn_tc | output | 1 | One-cycle pulse after a down wrap, or after a reload in reload mode |

## Verification
The assertions check the following on every cycle: the priority of clear over load, the hold when the enables agree, the wrap condition behind each strobe, the reload at count 1, and that the two strobes never overlap. Some behaviours show up only in the bench's scenarios against its reference model. These are the full carry and borrow sweeps across the digit boundary, the P, P-1, …, 1 sequence and its pulse spacing for two different presets, the entry into reload from 0, and the constant output with a zero preset.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } dir_e;

  function automatic dir_e dir_of(input logic up, input logic dn);
    if (up && !dn)      return DIR_UP;
    else if (dn && !up) return DIR_DOWN;
    else                return DIR_HOLD;
  endfunction
endpackage

// File: rtl/updn_digit.sv
module updn_digit #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [DW-1:0] value,
  output logic          all_ones,
  output logic          all_zero
);
  logic [DW-1:0] val_q, val_d;

  always_comb begin
    val_d = val_q;
    if (clr)          val_d = '0;
    else if (load)    val_d = load_val;
    else if (step_up) val_d = val_q + DW'(1);
    else if (step_dn) val_d = val_q - DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value    = val_q;
  assign all_ones = &val_q;
  assign all_zero = ~|val_q;

  assert_digit_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val_q == '0));

  assert_digit_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !step_up && !step_dn) |=> $stable(val_q));

  assert_digit_onehot_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
endmodule

// File: rtl/updn_pulse.sv
module updn_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  logic p_q, p_d;

  always_comb p_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) p_q <= 1'b0;
    else        p_q <= p_d;
  end

  assign pulse = p_q;
endmodule

// File: rtl/updn_divider.sv
module updn_divider #(
  parameter int DIGIT_W = 4,
  parameter int STAGES  = 2,
  localparam int W      = DIGIT_W * STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         up_en,
  input  logic         dn_en,
  input  logic         reload_en,
  input  logic         load_n,
  input  logic [W-1:0] preset,
  output logic [W-1:0] count,
  output logic         up_tc,
  output logic         dn_tc
);
  import updn_pkg::*;

  dir_e                 dir;
  logic                 up_go, dn_go;
  logic [STAGES:0]      up_carry, dn_borrow;
  logic [STAGES-1:0]    dig_ones, dig_zero;
  logic                 cnt_is_one, cnt_is_zero;
  logic                 reload_hit, reload_pulse, load_any;
  logic                 up_fire, dn_fire;

  always_comb begin
    dir   = dir_of(up_en, dn_en);
    up_go = (dir == DIR_UP);
    dn_go = (dir == DIR_DOWN);
  end

  assign up_carry[0]  = up_go;
  assign dn_borrow[0] = dn_go;

  assign cnt_is_zero = &dig_zero;
  assign cnt_is_one  = (count == W'(1));

  always_comb begin
    reload_hit   = reload_en && dn_go && (cnt_is_one || cnt_is_zero);
    reload_pulse = reload_en && dn_go && cnt_is_one;
    load_any     = !load_n || reload_hit;
  end

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_digit
      updn_digit #(.DW(DIGIT_W)) u_digit (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .load     (load_any),
        .load_val (preset[g*DIGIT_W +: DIGIT_W]),
        .step_up  (up_carry[g]),
        .step_dn  (dn_borrow[g]),
        .value    (count[g*DIGIT_W +: DIGIT_W]),
        .all_ones (dig_ones[g]),
        .all_zero (dig_zero[g])
      );
      assign up_carry[g+1]  = up_carry[g]  && dig_ones[g];
      assign dn_borrow[g+1] = dn_borrow[g] && dig_zero[g];
    end
  endgenerate

  always_comb begin
    up_fire = !clr && load_n && up_carry[STAGES];
    if (reload_en) dn_fire = !clr && load_n && reload_pulse;
    else           dn_fire = !clr && load_n && dn_borrow[STAGES];
  end

  updn_pulse u_up_tc (.clk(clk), .rst_n(rst_n), .fire(up_fire), .pulse(up_tc));
  updn_pulse u_dn_tc (.clk(clk), .rst_n(rst_n), .fire(dn_fire), .pulse(dn_tc));

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !up_tc && !dn_tc));

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (count == $past(preset) && !up_tc && !dn_tc));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && (up_en == dn_en)) |=> $stable(count));

  assert_up_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_tc |-> (count == '0 && $past(count) == {W{1'b1}}));

  assert_dn_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_tc && !$past(reload_en)) |-> (count == {W{1'b1}}));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && reload_en && dn_en && !up_en && count == W'(1))
      |=> (dn_tc && count == $past(preset)));

  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_tc && dn_tc));
endmodule

// File: tb/tb_updn_divider.sv
module tb_updn_divider;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr, up_en, dn_en, reload_en, load_n;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         up_tc, dn_tc;

  updn_divider dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .up_en(up_en), .dn_en(dn_en),
    .reload_en(reload_en), .load_n(load_n), .preset(preset),
    .count(count), .up_tc(up_tc), .dn_tc(dn_tc)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [W-1:0] cnt;
    logic         utc;
    logic         dtc;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int dn_pulses = 0;
  logic [W-1:0] m_cnt;
  bit done = 0;

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected result
  task automatic drive(input logic c, input logic ln, input logic u, input logic d,
                       input logic rl, input logic [W-1:0] p, input string tag);
    exp_t e;
    clr = c; load_n = ln; up_en = u; dn_en = d; reload_en = rl; preset = p;
    e.utc = 1'b0; e.dtc = 1'b0; e.tag = tag;
    if (c) m_cnt = '0;
    else if (!ln) m_cnt = p;
    else if (u && !d) begin
      e.utc = (m_cnt == MAXV);
      m_cnt = m_cnt + 1'b1;
    end else if (d && !u) begin
      if (rl) begin
        if (m_cnt == W'(1)) begin m_cnt = p; e.dtc = 1'b1; end
        else if (m_cnt == '0) m_cnt = p;
        else m_cnt = m_cnt - 1'b1;
      end else begin
        e.dtc = (m_cnt == '0);
        m_cnt = m_cnt - 1'b1;
      end
    end
    e.cnt = m_cnt;
    exp_q.push_back(e);
    @(negedge clk);
    #1;
  endtask

  // Monitor: compare results one negedge after the edge that produced them
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      if (dn_tc) dn_pulses++;
      checks++;
      if (count !== e.cnt || up_tc !== e.utc || dn_tc !== e.dtc) begin
        errors++;
        $display("FAIL %s count=%0h exp=%0h up_tc=%b exp=%b dn_tc=%b exp=%b",
                 e.tag, count, e.cnt, up_tc, e.utc, dn_tc, e.dtc);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; up_en = 1'b1; dn_en = 1'b0; reload_en = 1'b0;
    load_n = 1'b1; preset = 8'h3C; m_cnt = '0;
    repeat (3) @(negedge clk);
    check(count == '0 && !up_tc && !dn_tc,
          $sformatf("R1 reset count=%0h exp=0 up_tc=%b dn_tc=%b exp=0", count, up_tc, dn_tc));
    #1 rst_n = 1'b1;

    // R3 / R6: full up sweep across the digit carry and the top wrap
    for (int i = 0; i < 260; i++) drive(0, 1, 1, 0, 0, 8'h00, "R3_R6 up");
    // R5: both enables, then neither
    for (int i = 0; i < 3; i++) drive(0, 1, 1, 1, 0, 8'h00, "R5 both");
    for (int i = 0; i < 3; i++) drive(0, 1, 0, 0, 1, 8'h00, "R5 none");
    // R4 / R7: full down sweep with borrow and wrap
    drive(0, 0, 0, 0, 0, 8'h12, "R2 load");
    for (int i = 0; i < 260; i++) drive(0, 1, 0, 1, 0, 8'h00, "R4_R7 down");
    // R2: load overrides up counting and reload
    drive(0, 0, 1, 0, 0, 8'hA5, "R2 load over up");
    drive(0, 0, 0, 1, 1, 8'h01, "R2 load over reload");
    drive(0, 1, 1, 0, 0, 8'h00, "R3 after load");
    // R1: clear beats load and counting
    drive(1, 0, 1, 0, 0, 8'h77, "R1 clr over load");
    drive(1, 1, 0, 1, 0, 8'h77, "R1 clr over down");
    // R9: reload from 0 takes preset without a pulse
    drive(0, 1, 0, 1, 1, 8'h05, "R9 reload from 0");
    // R8: divide by 5
    dn_pulses = 0;
    for (int i = 0; i < 20; i++) drive(0, 1, 0, 1, 1, 8'h05, "R8 div5");
    drive(0, 1, 0, 0, 1, 8'h05, "R5 idle");
    check(dn_pulses == 4, $sformatf("R8 div5 pulses act=%0d exp=4", dn_pulses));
    // R8: change preset to 3, ratio follows
    for (int i = 0; i < 2; i++) drive(0, 1, 0, 1, 1, 8'h03, "R8 to div3");
    dn_pulses = 0;
    for (int i = 0; i < 15; i++) drive(0, 1, 0, 1, 1, 8'h03, "R8 div3");
    drive(0, 1, 0, 0, 1, 8'h03, "R5 idle");
    check(dn_pulses == 5, $sformatf("R8 div3 pulses act=%0d exp=5", dn_pulses));
    // R9: preset 0 holds the output constant
    for (int i = 0; i < 4; i++) drive(0, 1, 0, 1, 1, 8'h00, "R9 to zero");
    dn_pulses = 0;
    for (int i = 0; i < 10; i++) drive(0, 1, 0, 1, 1, 8'h00, "R9 preset0");
    drive(0, 1, 0, 0, 1, 8'h00, "R5 idle");
    check(dn_pulses == 0 && count == '0,
          $sformatf("R9 preset0 pulses act=%0d exp=0 count=%0h exp=0", dn_pulses, count));
    // R7 / R10: leave reload, down wrap from 0, then up wrap from max
    drive(0, 1, 0, 1, 0, 8'h00, "R7 wrap after reload");
    drive(0, 1, 1, 0, 0, 8'h00, "R6_R10 up wrap");
    drive(0, 1, 0, 1, 0, 8'h00, "R7_R10 down wrap");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule